// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that runs from a slow clock. A prescaler divides that clock into ticks, and each tick decrements a 12-bit down-counter. Software must send a keyed restart command before the counter runs out. A restart also has to fall inside a permitted window: the counter must already have dropped to the programmed window delta or below. A restart sent too early, or a counter that runs out, sets a status flag. If reset generation is enabled, the block also drives a reset request pulse of fixed length.

The block is configured through one mode word, and only the first write to that word takes effect. The counter is never loaded just because the watchdog is enabled. A counter left at zero therefore expires on the first tick unless a restart comes first. A mode write that changes the reload or window value within a few cycles after a restart forces the counter to zero, so that end of period comes early. Access is through a simple register port: a 2-bit address, write and read strobes, and 32-bit data.

Top module: `wdt_window_top`

## Requirements
- R1: After reset the mode word reads 0x0FFFAFFF, the status word reads 0, `rst_req` is low and the down-counter holds 0.
- R2: Address 1 is the mode word, address 0 the command word and address 2 the status word. In the mode word, bits 11:0 are the reload value, bits 27:16 the window delta, bit 15 disables the watchdog when set, and bit 13 enables reset requests. In the status word, bit 0 is the underflow flag and bit 1 the window error flag.
- R3: The first write to the mode word stores the word and locks it. Later mode writes are ignored, and reads still return the stored value.
- R4: A write to address 0 is a restart only when bits 31:24 equal 0xA5 and bit 0 is set. Any other write to address 0 has no effect.
- R5: A restart loads the counter from the reload value and clears the prescaler. If no further restart arrives, the underflow comes (reload+1)×PRESCALE cycles after the restart edge.
- R6: Enabling the watchdog while the counter holds 0, with no restart, gives an underflow on the first tick, PRESCALE cycles after the enabling write.
- R7: An underflow sets status bit 0 and reloads the counter from the reload value.
- R8: Each underflow or window error drives `rst_req` high for RST_LEN cycles when mode bit 13 is set. When bit 13 is clear, `rst_req` stays low.
- R9: A restart while the watchdog is enabled and the counter is above the window delta sets status bit 1 and is a fault. A restart with the counter at or below the delta is not a fault.
- R10: Reading the status word clears both flags.
- R11: A mode write within GUARD_CYC cycles after a restart that changes the reload or window value forces the counter to 0. A mode write made after that guard has run out does not.
- R12: While the watchdog is disabled, the counter and prescaler hold, and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational, valid while `rd_en` is high) |
| rst_req | output | 1 | Reset request pulse |

## Verification
The hardest case to reach is the guard window after a restart. Because the mode word locks on its first write, the only mode write that can fall inside the guard is that first write. The stimulus therefore sends a keyed restart while the watchdog is still disabled and writes the first mode word one cycle later. It then repeats the sequence with the write moved just past the guard. The stale-zero expiry and the window check are reached the same way: each scenario starts from reset so the one-time mode write can be placed on an exact cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [1:0] ADDR_CMD  = 2'd0;
   localparam logic [1:0] ADDR_MODE = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   localparam int FIELD_W   = 12;
   localparam int RELOAD_LSB = 0;
   localparam int DELTA_LSB  = 16;
   localparam int DIS_BIT    = 15;
   localparam int RSTEN_BIT  = 13;
   localparam int KEY_LSB    = 24;

   localparam logic [31:0] MODE_RESET = 32'h0FFF_AFFF;

   function automatic logic [FIELD_W-1:0] reload_of(input logic [31:0] m);
      return m[RELOAD_LSB +: FIELD_W];
   endfunction

   function automatic logic [FIELD_W-1:0] delta_of(input logic [31:0] m);
      return m[DELTA_LSB +: FIELD_W];
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam bit POW2 = (PRESCALE == (1 << PW));

   logic [PW-1:0] pre_q;
   logic          wrap;

   generate
      if (POW2) begin : g_pow2
         assign wrap = &pre_q;
      end else begin : g_cmp
         assign wrap = (pre_q == PW'(PRESCALE - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clear || !run || wrap)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

   assign tick = run && wrap;
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         force_zero,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         underflow
);
   logic [W-1:0] cnt_q;

   assign underflow = tick && !load && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (force_zero)
         cnt_q <= '0;
      else if (underflow)
         cnt_q <= load_val;
      else if (tick)
         cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter logic [7:0] KEY = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   input  logic        set_unf,
   input  logic        set_err,
   output logic [31:0] mode_q,
   output logic        locked,
   output logic        mode_wr,
   output logic        restart,
   output logic        unf_flag,
   output logic        err_flag,
   output logic [31:0] rdata
);
   logic stat_rd;

   assign mode_wr = wr_en && (addr == ADDR_MODE) && !locked;
   assign restart = wr_en && (addr == ADDR_CMD) &&
                    (wdata[KEY_LSB +: 8] == KEY) && wdata[0];
   assign stat_rd = rd_en && (addr == ADDR_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         locked <= 1'b0;
      end else if (mode_wr) begin
         mode_q <= wdata;
         locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unf_flag <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (set_unf)      unf_flag <= 1'b1;
         else if (stat_rd) unf_flag <= 1'b0;
         if (set_err)      err_flag <= 1'b1;
         else if (stat_rd) err_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_MODE: rdata = mode_q;
            ADDR_STAT: rdata = {30'd0, err_flag, unf_flag};
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(LEN + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (trig)
         left_q <= CW'(LEN);
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
   import wdt_pkg::*;
#(
   parameter int         PRESCALE  = 128,
   parameter int         RST_LEN   = 16,
   parameter int         GUARD_CYC = 3,
   parameter logic [7:0] KEY       = 8'hA5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        rst_req
);
   localparam int GW = $clog2(GUARD_CYC + 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if (RST_LEN < 1) begin : g_bad_len
         $error("RST_LEN must be at least 1");
      end
      if (GUARD_CYC < 1) begin : g_bad_guard
         $error("GUARD_CYC must be at least 1");
      end
   endgenerate

   logic [31:0]        mode_q;
   logic               locked, mode_wr, restart;
   logic               unf_flag, err_flag;
   logic               enabled, rsten, tick;
   logic [FIELD_W-1:0] cnt_q;
   logic               underflow, winerr, fault_trig;
   logic               fields_change, force_zero;
   logic [GW-1:0]      guard_q;

   wdt_regs #(.KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .set_unf(underflow), .set_err(winerr),
      .mode_q(mode_q), .locked(locked), .mode_wr(mode_wr),
      .restart(restart), .unf_flag(unf_flag), .err_flag(err_flag),
      .rdata(rdata)
   );

   assign enabled = !mode_q[DIS_BIT];
   assign rsten   = mode_q[RSTEN_BIT];

   wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(enabled), .clear(restart), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         guard_q <= '0;
      else if (restart)
         guard_q <= GW'(GUARD_CYC);
      else if (guard_q != '0)
         guard_q <= guard_q - 1'b1;
   end

   assign fields_change = (reload_of(wdata) != reload_of(mode_q)) ||
                          (delta_of(wdata)  != delta_of(mode_q));
   assign force_zero    = mode_wr && (guard_q != '0) && fields_change;

   wdt_downcounter #(.W(FIELD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(restart), .load_val(reload_of(mode_q)),
      .force_zero(force_zero), .tick(tick), .cnt(cnt_q), .underflow(underflow)
   );

   assign winerr     = restart && enabled && (cnt_q > delta_of(mode_q));
   assign fault_trig = (underflow || winerr) && rsten;

   wdt_pulse #(.LEN(RST_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(fault_trig), .active(rst_req)
   );
endmodule

// File: rtl/wdt_window_checker.sv
module wdt_window_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        locked,
   input logic [31:0] mode_q,
   input logic        restart,
   input logic        mode_wr,
   input logic [11:0] cnt,
   input logic        underflow,
   input logic        unf_flag,
   input logic        winerr,
   input logic        err_flag,
   input logic        rst_req,
   input logic        fault
);
   assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode_q));

   assert_restart_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == $past(mode_q[11:0])));

   assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> unf_flag);

   assert_window_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      winerr |=> err_flag);

   assert_reset_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(fault));

   assert_disabled_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[15] && !restart && !mode_wr) |=> $stable(cnt));
endmodule

bind wdt_window_top wdt_window_checker u_chk (
   .clk(clk), .rst_n(rst_n), .locked(locked), .mode_q(mode_q),
   .restart(restart), .mode_wr(mode_wr), .cnt(cnt_q), .underflow(underflow),
   .unf_flag(unf_flag), .winerr(winerr), .err_flag(err_flag),
   .rst_req(rst_req), .fault(fault_trig)
);

// File: tb/wdt_window_top_bench.sv
`timescale 1ns/1ps
module wdt_window_top_bench;
   localparam int P = 4;
   localparam int RL = 5;
   localparam int GC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdt_window_top #(.PRESCALE(P), .RST_LEN(RL), .GUARD_CYC(GC)) u_wdt_window_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
   );

   // behavioural reference model
   logic [31:0] m_mode;
   bit m_locked, m_unf, m_err;
   int m_pre, m_cnt, m_guard, m_pulse;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 32'h0FFF_AFFF; m_locked = 0; m_unf = 0; m_err = 0;
         m_pre = 0; m_cnt = 0; m_guard = 0; m_pulse = 0;
      end else begin
         bit rs, mw, en, tk, uf, we, ch, sr;
         int rel, dl;
         rs  = wr_en && addr == 2'd0 && wdata[31:24] == 8'hA5 && wdata[0];
         mw  = wr_en && addr == 2'd1 && !m_locked;
         sr  = rd_en && addr == 2'd2;
         en  = !m_mode[15];
         rel = int'(m_mode[11:0]);
         dl  = int'(m_mode[27:16]);
         tk  = en && (m_pre == P - 1);
         uf  = tk && !rs && m_cnt == 0;
         we  = rs && en && m_cnt > dl;
         ch  = (wdata[11:0] != m_mode[11:0]) || (wdata[27:16] != m_mode[27:16]);
         if (rs) m_cnt = rel;
         else if (mw && m_guard > 0 && ch) m_cnt = 0;
         else if (uf) m_cnt = rel;
         else if (tk) m_cnt = m_cnt - 1;
         m_pre = (rs || !en || m_pre == P - 1) ? 0 : m_pre + 1;
         if ((uf || we) && m_mode[13]) m_pulse = RL;
         else if (m_pulse > 0) m_pulse--;
         m_guard = rs ? GC : (m_guard > 0 ? m_guard - 1 : 0);
         m_unf = uf ? 1'b1 : (sr ? 1'b0 : m_unf);
         m_err = we ? 1'b1 : (sr ? 1'b0 : m_err);
         if (mw) begin m_mode = wdata; m_locked = 1; end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // per-cycle comparison of the reset request against the model (R8)
   always @(negedge clk) begin
      if (rst_n && !done)
         chk(rst_req === (m_pulse != 0), "R8 rst_req vs model",
             {31'd0, rst_req}, {31'd0, m_pulse != 0});
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      logic [31:0] e;
      rd_en = 1'b1; addr = a;
      #1;
      v = rdata;
      e = (a == 2'd1) ? m_mode : (a == 2'd2) ? {30'd0, m_err, m_unf} : 32'd0;
      chk(v === e, "R2 read vs model", v, e);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_req(output int n);
      n = 0;
      while (!rst_req && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int n, hi;
      @(negedge clk);
      do_reset();

      // R1 reset state
      rd(2'd1, v); chk(v == 32'h0FFF_AFFF, "R1 reset mode", v, 32'h0FFF_AFFF);
      rd(2'd2, v); chk(v == 0, "R1 reset status", v, 0);
      chk(rst_req == 0, "R1 reset rst_req", {31'd0, rst_req}, 0);
      // R12 disabled: nothing happens
      idle(40);
      rd(2'd2, v); chk(v == 0, "R12 disabled no underflow", v, 0);

      // R6 stale zero, R4 bad key ignored
      wr(2'd1, 32'h0FFF_2003);
      wr(2'd0, 32'h5A00_0001);
      wait_req(n);
      chk(n == P - 1, "R6/R4 stale zero expiry cycles", n, P - 1);
      hi = 0;
      while (rst_req && hi < 50) begin @(negedge clk); hi++; end
      chk(hi == RL, "R8 pulse length", hi, RL);
      rd(2'd2, v); chk(v == 32'h1, "R7 underflow flag", v, 1);
      rd(2'd2, v); chk(v == 32'h0, "R10 status cleared by read", v, 0);
      wr(2'd1, 32'h0000_0000);
      rd(2'd1, v); chk(v == 32'h0FFF_2003, "R3 locked mode", v, 32'h0FFF_2003);

      // R5 restart timing
      do_reset();
      wr(2'd1, 32'h0FFF_2005);
      wr(2'd0, 32'hA500_0001);
      wait_req(n);
      chk(n == 6 * P, "R5 restart timeout", n, 6 * P);
      idle(RL + 1);
      rd(2'd2, v); chk(v == 32'h1, "R5 underflow after timeout", v, 1);

      // R9 window
      do_reset();
      wr(2'd1, 32'h0002_2008);
      wr(2'd0, 32'hA500_0001);
      wr(2'd0, 32'hA500_0001);
      chk(rst_req == 1, "R9 early restart fault", {31'd0, rst_req}, 1);
      rd(2'd2, v); chk(v == 32'h2, "R9 window error flag", v, 2);
      idle(24);
      wr(2'd0, 32'hA500_0001);
      rd(2'd2, v); chk(v == 32'h0, "R9 in-window restart no fault", v, 0);

      // R8 reset enable clear
      do_reset();
      wr(2'd1, 32'h0FFF_0000);
      hi = 0;
      repeat (20) begin @(negedge clk); if (rst_req) hi++; end
      chk(hi == 0, "R8 no request when bit13 clear", hi, 0);
      rd(2'd2, v); chk(v == 32'h1, "R8 flag still set", v, 1);

      // R11 guard early expiry
      do_reset();
      wr(2'd0, 32'hA500_0001);
      wr(2'd1, 32'h0FFF_2010);
      wait_req(n);
      chk(n == P, "R11 early expiry inside guard", n, P);
      do_reset();
      wr(2'd0, 32'hA500_0001);
      idle(GC);
      wr(2'd1, 32'h0FFF_2010);
      hi = 0;
      repeat (40) begin @(negedge clk); if (rst_req) hi++; end
      chk(hi == 0, "R11 no early expiry after guard", hi, 0);
      rd(2'd2, v); chk(v == 0, "R11 status clean after guard", v, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule